// File: doc/BRIEF.md
# Software-Refilled Translation Buffer

This block holds a small set of virtual-to-physical page translations for the running address space. Every slot is compared against a lookup at once, so a hit returns the physical address and its permission flags in the same cycle as the request. Pages are 4096 bytes. The low 12 address bits are the page offset and pass through unchanged. The upper 20 bits form the virtual page number, and they are replaced by the stored frame number.

The block never fetches a translation by itself. A lookup that finds no slot raises a miss exception and changes nothing. System software then finds the translation in its own tables and installs it through the management port. That port can search for a page/space pair, read back a slot, load a chosen slot, load a pseudo-randomly chosen slot that is not among the pinned low slots, or drop every translation in one cycle. Each slot carries an address-space tag and a global bit. A process switch therefore only needs to change the current tag, although a full flush also works.

Top module: `soft_tlb`

## Requirements
- R1: On a hit, lk_paddr is the hit slot's 20-bit frame number above lk_vaddr[11:0], and lk_perm is that slot's permission field. On a miss, or while lk_en is low, both are zero.
- R2: A slot matches only when its valid bit is set, its page number equals lk_vaddr[31:12], and either its space tag equals cur_asid or its global bit is set. When lk_en is low, lk_hit, lk_miss_exc and lk_mod_exc are all low.
- R3: When lk_en is high and no slot matches, lk_miss_exc is high and lk_hit is low. A miss changes no slot.
- R4: lk_mod_exc is high when a lookup with lk_write high hits a slot whose dirty bit is clear. It is low for read lookups and for hits on dirty slots.
- R5: Probe (mg_op=1) searches for the pair mg_vpn/mg_asid with the lookup matching rule. On the next cycle, pr_index holds the lowest matching slot and pr_miss is 0; if nothing matches, pr_index is 0 and pr_miss is 1. Both outputs hold their value until the next probe.
- R6: Read (mg_op=2) copies every field of slot mg_index to the rd_* outputs on the next cycle. The rd_* outputs hold until the next read.
- R7: Indexed write (mg_op=3) loads slot mg_index from the mg_* fields. The write is visible from the next cycle; a lookup or probe in the same cycle sees the old contents.
- R8: Random write (mg_op=4) loads a slot whose index lies between mg_wired and the top slot. Slots below mg_wired are never changed by it.
- R9: Flush (mg_op=5) clears the valid bit of every slot in one cycle, so no lookup hits on the following cycle. Other stored fields are kept.
- R10: If more than one slot matches a lookup, lk_multi is high and the lowest matching index supplies the result.
- R11: After reset, no slot is valid, pr_index, pr_miss and every rd_* output are zero, and every lookup misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_en | input | 1 | Lookup request |
| lk_write | input | 1 | The lookup is for a store |
| lk_vaddr | input | 32 | Virtual address to translate |
| cur_asid | input | 8 | Tag of the current address space |
| lk_hit | output | 1 | A slot matched |
| lk_miss_exc | output | 1 | Miss exception |
| lk_mod_exc | output | 1 | Store to a clean page |
| lk_multi | output | 1 | More than one slot matched |
| lk_paddr | output | 32 | Translated physical address |
| lk_perm | output | 2 | Permission bits of the hit slot |
| mg_op | input | 3 | 0 idle, 1 probe, 2 read, 3 indexed write, 4 random write, 5 flush |
| mg_index | input | 4 | Slot for read and indexed write |
| mg_wired | input | 4 | Number of pinned low slots that random write skips |
| mg_vpn | input | 20 | Page number for probe and write |
| mg_asid | input | 8 | Space tag for probe and write |
| mg_pfn | input | 20 | Frame number to write |
| mg_valid | input | 1 | Valid bit to write |
| mg_global | input | 1 | Global bit to write |
| mg_dirty | input | 1 | Dirty (store-enable) bit to write |
| mg_perm | input | 2 | Permission bits to write |
| pr_index | output | 4 | Probe result slot |
| pr_miss | output | 1 | Probe found nothing |
| rd_vpn | output | 20 | Read-back page number |
| rd_asid | output | 8 | Read-back space tag |
| rd_pfn | output | 20 | Read-back frame number |
| rd_valid | output | 1 | Read-back valid bit |
| rd_global | output | 1 | Read-back global bit |
| rd_dirty | output | 1 | Read-back dirty bit |
| rd_perm | output | 2 | Read-back permission bits |

## Verification
The hardest state to reach from the ports is a random write whose target the stimulus cannot name in advance. The bench follows each random write with a probe for the same unique page, learns the chosen slot from the probe result, checks that slot against the pinned range, and updates its model. Later reads of the pinned slots confirm they were left alone. Duplicate matches are just as rare by chance, so they are built on purpose: two slots get the same page and tag. The random phase then draws from a pool of only eight page numbers and four tags, which makes overlapping entries, global overrides and lookups in the same cycle as a write occur many times.

// File: rtl/soft_tlb_pkg.sv
package soft_tlb_pkg;
  localparam int VA_W   = 32;
  localparam int OFF_W  = 12;
  localparam int VPN_W  = VA_W - OFF_W;
  localparam int PFN_W  = VA_W - OFF_W;
  localparam int ASID_W = 8;
  localparam int PERM_W = 2;

  typedef struct packed {
    logic              valid;
    logic              glob;
    logic              dirty;
    logic [PERM_W-1:0] perm;
    logic [ASID_W-1:0] asid;
    logic [VPN_W-1:0]  vpn;
    logic [PFN_W-1:0]  pfn;
  } tlb_entry_t;

  typedef enum logic [2:0] {
    MG_IDLE  = 3'd0,
    MG_PROBE = 3'd1,
    MG_READ  = 3'd2,
    MG_WIDX  = 3'd3,
    MG_WRND  = 3'd4,
    MG_FLUSH = 3'd5
  } mg_op_e;
endpackage

// File: rtl/soft_tlb_match.sv
module soft_tlb_match
  import soft_tlb_pkg::*;
#(
  parameter int N  = 16,
  parameter int IW = $clog2(N)
) (
  input  tlb_entry_t        ent [N],
  input  logic [VPN_W-1:0]  vpn,
  input  logic [ASID_W-1:0] asid,
  output logic [N-1:0]      vec,
  output logic              any,
  output logic              multi,
  output logic [IW-1:0]     idx
);
  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign vec[i] = ent[i].valid && (ent[i].vpn == vpn) &&
                    (ent[i].glob || (ent[i].asid == asid));
  end

  // lowest matching index wins
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end

  assign any   = |vec;
  assign multi = |(vec & (vec - N'(1)));
endmodule

// File: rtl/soft_tlb_store.sv
module soft_tlb_store
  import soft_tlb_pkg::*;
#(
  parameter int N  = 16,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [IW-1:0] widx,
  input  tlb_entry_t    wdata,
  input  logic          flush,
  output tlb_entry_t    ent [N]
);
  for (genvar i = 0; i < N; i++) begin : g_slot
    logic       sel;
    logic       v_d, v_q;
    tlb_entry_t d_q;

    assign sel = we && (widx == IW'(i));

    always_comb begin
      v_d = v_q;
      if (flush)    v_d = 1'b0;
      else if (sel) v_d = wdata.valid;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) v_q <= 1'b0;
      else        v_q <= v_d;
    end

    // data fields carry no reset; only the valid bit qualifies them
    always_ff @(posedge clk) begin
      if (sel) d_q <= wdata;
    end

    always_comb begin
      ent[i]       = d_q;
      ent[i].valid = v_q;
    end
  end
endmodule

// File: rtl/soft_tlb_victim.sv
module soft_tlb_victim #(
  parameter int N  = 16,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] wired,
  output logic [IW-1:0] rnd_idx
);
  localparam logic [IW-1:0] TOP = IW'(N - 1);

  logic [IW-1:0] lower;
  logic [IW-1:0] cnt_d, cnt_q;

  assign lower = (wired > TOP) ? TOP : wired;

  // free-running down counter that wraps above the pinned region
  always_comb begin
    if (cnt_q <= lower) cnt_d = TOP;
    else                cnt_d = cnt_q - IW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= TOP;
    else        cnt_q <= cnt_d;
  end

  assign rnd_idx = (cnt_q < lower) ? TOP : cnt_q;
endmodule

// File: rtl/soft_tlb.sv
module soft_tlb
  import soft_tlb_pkg::*;
#(
  parameter  int ENTRIES = 16,
  localparam int IW      = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_en,
  input  logic              lk_write,
  input  logic [VA_W-1:0]   lk_vaddr,
  input  logic [ASID_W-1:0] cur_asid,
  output logic              lk_hit,
  output logic              lk_miss_exc,
  output logic              lk_mod_exc,
  output logic              lk_multi,
  output logic [VA_W-1:0]   lk_paddr,
  output logic [PERM_W-1:0] lk_perm,
  input  logic [2:0]        mg_op,
  input  logic [IW-1:0]     mg_index,
  input  logic [IW-1:0]     mg_wired,
  input  logic [VPN_W-1:0]  mg_vpn,
  input  logic [ASID_W-1:0] mg_asid,
  input  logic [PFN_W-1:0]  mg_pfn,
  input  logic              mg_valid,
  input  logic              mg_global,
  input  logic              mg_dirty,
  input  logic [PERM_W-1:0] mg_perm,
  output logic [IW-1:0]     pr_index,
  output logic              pr_miss,
  output logic [VPN_W-1:0]  rd_vpn,
  output logic [ASID_W-1:0] rd_asid,
  output logic [PFN_W-1:0]  rd_pfn,
  output logic              rd_valid,
  output logic              rd_global,
  output logic              rd_dirty,
  output logic [PERM_W-1:0] rd_perm
);
  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta_n, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  mg_op_e op;
  assign op = mg_op_e'(mg_op);

  tlb_entry_t         ent [ENTRIES];
  logic [ENTRIES-1:0] lk_vec, pr_vec;
  logic               lk_any, lk_mul, pr_any, pr_mul;
  logic [IW-1:0]      lk_idx, pr_idx_c, rnd_idx;
  tlb_entry_t         lk_ent;

  // lookup comparator bank
  soft_tlb_match #(.N(ENTRIES), .IW(IW)) u_lk_match (
    .ent  (ent),
    .vpn  (lk_vaddr[VA_W-1:OFF_W]),
    .asid (cur_asid),
    .vec  (lk_vec),
    .any  (lk_any),
    .multi(lk_mul),
    .idx  (lk_idx)
  );

  // probe comparator bank
  soft_tlb_match #(.N(ENTRIES), .IW(IW)) u_pr_match (
    .ent  (ent),
    .vpn  (mg_vpn),
    .asid (mg_asid),
    .vec  (pr_vec),
    .any  (pr_any),
    .multi(pr_mul),
    .idx  (pr_idx_c)
  );

  soft_tlb_victim #(.N(ENTRIES), .IW(IW)) u_victim (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .wired  (mg_wired),
    .rnd_idx(rnd_idx)
  );

  logic          st_we, st_flush;
  logic [IW-1:0] st_idx;
  tlb_entry_t    st_data;

  always_comb begin
    st_we          = (op == MG_WIDX) || (op == MG_WRND);
    st_flush       = (op == MG_FLUSH);
    st_idx         = (op == MG_WRND) ? rnd_idx : mg_index;
    st_data.valid  = mg_valid;
    st_data.glob   = mg_global;
    st_data.dirty  = mg_dirty;
    st_data.perm   = mg_perm;
    st_data.asid   = mg_asid;
    st_data.vpn    = mg_vpn;
    st_data.pfn    = mg_pfn;
  end

  soft_tlb_store #(.N(ENTRIES), .IW(IW)) u_store (
    .clk  (clk),
    .rst_n(rst_sync_n),
    .we   (st_we),
    .widx (st_idx),
    .wdata(st_data),
    .flush(st_flush),
    .ent  (ent)
  );

  // lookup result, combinational
  assign lk_ent      = ent[lk_idx];
  assign lk_hit      = lk_en & lk_any;
  assign lk_miss_exc = lk_en & ~lk_any;
  assign lk_mod_exc  = lk_hit & lk_write & ~lk_ent.dirty;
  assign lk_multi    = lk_en & lk_mul;
  assign lk_paddr    = lk_hit ? {lk_ent.pfn, lk_vaddr[OFF_W-1:0]} : '0;
  assign lk_perm     = lk_hit ? lk_ent.perm : '0;

  // probe and read result registers
  logic          pr_en, rd_en;
  logic [IW-1:0] pr_idx_d, pr_idx_q;
  logic          pr_miss_d, pr_miss_q;
  tlb_entry_t    rd_d, rd_q;

  always_comb begin
    pr_en     = (op == MG_PROBE);
    rd_en     = (op == MG_READ);
    pr_idx_d  = pr_idx_q;
    pr_miss_d = pr_miss_q;
    rd_d      = rd_q;
    if (pr_en) begin
      pr_idx_d  = pr_idx_c;
      pr_miss_d = ~pr_any;
    end
    if (rd_en) rd_d = ent[mg_index];
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      pr_idx_q  <= '0;
      pr_miss_q <= 1'b0;
      rd_q      <= '0;
    end else begin
      pr_idx_q  <= pr_idx_d;
      pr_miss_q <= pr_miss_d;
      rd_q      <= rd_d;
    end
  end

  assign pr_index  = pr_idx_q;
  assign pr_miss   = pr_miss_q;
  assign rd_vpn    = rd_q.vpn;
  assign rd_asid   = rd_q.asid;
  assign rd_pfn    = rd_q.pfn;
  assign rd_valid  = rd_q.valid;
  assign rd_global = rd_q.glob;
  assign rd_dirty  = rd_q.dirty;
  assign rd_perm   = rd_q.perm;
endmodule

// File: rtl/soft_tlb_chk.sv
module soft_tlb_chk
  import soft_tlb_pkg::*;
#(
  parameter int IW = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            lk_en,
  input logic            lk_write,
  input logic [VA_W-1:0] lk_vaddr,
  input logic            lk_hit,
  input logic            lk_miss_exc,
  input logic            lk_mod_exc,
  input logic            lk_multi,
  input logic [VA_W-1:0] lk_paddr,
  input logic [2:0]      mg_op,
  input logic [IW-1:0]   pr_index,
  input logic            pr_miss
);
  AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (lk_paddr[OFF_W-1:0] == lk_vaddr[OFF_W-1:0])); // R1

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_en |-> (!lk_hit && !lk_miss_exc && !lk_mod_exc)); // R2

  AST_HIT_XOR_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    lk_en |-> (lk_hit ^ lk_miss_exc)); // R3

  AST_MOD_NEEDS_STORE_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    lk_mod_exc |-> (lk_hit && lk_write)); // R4

  AST_PROBE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mg_op != 3'd1) |=> ($stable(pr_index) && $stable(pr_miss))); // R5

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (mg_op == 3'd5) |=> !lk_hit); // R9

  AST_MULTI_IS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    lk_multi |-> lk_hit); // R10
endmodule

bind soft_tlb soft_tlb_chk #(.IW(IW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .lk_en      (lk_en),
  .lk_write   (lk_write),
  .lk_vaddr   (lk_vaddr),
  .lk_hit     (lk_hit),
  .lk_miss_exc(lk_miss_exc),
  .lk_mod_exc (lk_mod_exc),
  .lk_multi   (lk_multi),
  .lk_paddr   (lk_paddr),
  .mg_op      (mg_op),
  .pr_index   (pr_index),
  .pr_miss    (pr_miss)
);

// File: tb/test_soft_tlb.sv
`timescale 1ns/1ps
module test_soft_tlb;
  localparam int N  = 16;
  localparam int IW = 4;

  logic        clk, rst_n;
  logic        lk_en, lk_write;
  logic [31:0] lk_vaddr;
  logic [7:0]  cur_asid;
  logic        lk_hit, lk_miss_exc, lk_mod_exc, lk_multi;
  logic [31:0] lk_paddr;
  logic [1:0]  lk_perm;
  logic [2:0]  mg_op;
  logic [3:0]  mg_index, mg_wired;
  logic [19:0] mg_vpn, mg_pfn;
  logic [7:0]  mg_asid;
  logic        mg_valid, mg_global, mg_dirty;
  logic [1:0]  mg_perm;
  logic [3:0]  pr_index;
  logic        pr_miss;
  logic [19:0] rd_vpn, rd_pfn;
  logic [7:0]  rd_asid;
  logic        rd_valid, rd_global, rd_dirty;
  logic [1:0]  rd_perm;

  soft_tlb #(.ENTRIES(N)) i_soft_tlb (.*);

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int n_chk = 0, n_fail = 0;

  // model
  logic        m_v [N], m_g [N], m_d [N];
  logic [1:0]  m_perm [N];
  logic [7:0]  m_asid [N];
  logic [19:0] m_vpn [N], m_pfn [N];

  logic        pend_pr, pend_rd, free_probe;
  logic [3:0]  e_pr_idx, e_rd_idx_unused;
  logic        e_pr_miss;
  logic [3:0]  e_rd_idx;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int mdl_find(input logic [19:0] vpn, input logic [7:0] asid, output int cnt);
    int first = -1;
    cnt = 0;
    for (int i = 0; i < N; i++) begin
      if (m_v[i] && m_vpn[i] == vpn && (m_g[i] || m_asid[i] == asid)) begin
        if (first < 0) first = i;
        cnt++;
      end
    end
    return first;
  endfunction

  task automatic nxt();
    @(negedge clk);
    lk_en = 1'b0; lk_write = 1'b0; mg_op = 3'd0;
  endtask

  task automatic set_lk(input logic [31:0] va, input logic [7:0] asid, input logic wr);
    lk_en = 1'b1; lk_vaddr = va; cur_asid = asid; lk_write = wr;
  endtask

  task automatic set_wr(input logic [2:0] op, input logic [3:0] idx, input logic [19:0] vpn,
                        input logic [7:0] asid, input logic [19:0] pfn, input logic v,
                        input logic g, input logic d, input logic [1:0] perm);
    mg_op = op; mg_index = idx; mg_vpn = vpn; mg_asid = asid; mg_pfn = pfn;
    mg_valid = v; mg_global = g; mg_dirty = d; mg_perm = perm;
  endtask

  // check outputs of this cycle, then advance the model for this cycle's op
  task automatic eval();
    int fi, cnt;
    #1;
    if (pend_pr) begin
      chk("R5 probe index", 64'(pr_index), 64'(e_pr_idx));
      chk("R5 probe miss", 64'(pr_miss), 64'(e_pr_miss));
      pend_pr = 1'b0;
    end
    if (pend_rd) begin
      chk("R6 read valid", 64'(rd_valid), 64'(m_v[e_rd_idx]));
      chk("R6 read vpn", 64'(rd_vpn), 64'(m_vpn[e_rd_idx]));
      chk("R6 read pfn", 64'(rd_pfn), 64'(m_pfn[e_rd_idx]));
      chk("R6 read asid", 64'(rd_asid), 64'(m_asid[e_rd_idx]));
      chk("R6 read flags", 64'({rd_global, rd_dirty, rd_perm}),
          64'({m_g[e_rd_idx], m_d[e_rd_idx], m_perm[e_rd_idx]}));
      pend_rd = 1'b0;
    end
    if (lk_en) begin
      fi = mdl_find(lk_vaddr[31:12], cur_asid, cnt);
      chk("R2 hit", 64'(lk_hit), 64'(fi >= 0));
      chk("R3 miss exception", 64'(lk_miss_exc), 64'(fi < 0));
      chk("R10 multi", 64'(lk_multi), 64'(cnt > 1));
      if (fi >= 0) begin
        chk("R1 paddr", 64'(lk_paddr), 64'({m_pfn[fi], lk_vaddr[11:0]}));
        chk("R1 perm", 64'(lk_perm), 64'(m_perm[fi]));
        chk("R4 modify exception", 64'(lk_mod_exc), 64'(lk_write && !m_d[fi]));
      end else begin
        chk("R1 paddr on miss", 64'(lk_paddr), 64'd0);
        chk("R4 no modify on miss", 64'(lk_mod_exc), 64'd0);
      end
    end else begin
      chk("R2 idle quiet", 64'({lk_hit, lk_miss_exc, lk_mod_exc}), 64'd0);
    end
    case (mg_op)
      3'd1: if (!free_probe) begin
        fi = mdl_find(mg_vpn, mg_asid, cnt);
        e_pr_idx = (fi >= 0) ? 4'(fi) : 4'd0;
        e_pr_miss = (fi < 0);
        pend_pr = 1'b1;
      end
      3'd2: begin e_rd_idx = mg_index; pend_rd = 1'b1; end
      3'd3: begin
        m_v[mg_index] = mg_valid; m_g[mg_index] = mg_global; m_d[mg_index] = mg_dirty;
        m_perm[mg_index] = mg_perm; m_asid[mg_index] = mg_asid;
        m_vpn[mg_index] = mg_vpn; m_pfn[mg_index] = mg_pfn;
      end
      3'd5: for (int i = 0; i < N; i++) m_v[i] = 1'b0;
      default: ;
    endcase
  endtask

  // random write of a unique page, then locate it with a probe
  task automatic rnd_write(input logic [19:0] vpn, input logic [7:0] asid, input logic [19:0] pfn);
    logic [3:0] got;
    nxt(); set_wr(3'd4, 4'd0, vpn, asid, pfn, 1'b1, 1'b0, 1'b1, 2'b10); eval();
    nxt(); set_wr(3'd1, 4'd0, vpn, asid, 20'd0, 1'b0, 1'b0, 1'b0, 2'b00);
    free_probe = 1'b1; eval(); free_probe = 1'b0;
    nxt(); eval();
    chk("R8 random write found", 64'(pr_miss), 64'd0);
    chk("R8 random index above pinned", 64'(pr_index >= mg_wired), 64'd1);
    got = pr_index;
    m_v[got] = 1'b1; m_g[got] = 1'b0; m_d[got] = 1'b1; m_perm[got] = 2'b10;
    m_asid[got] = asid; m_vpn[got] = vpn; m_pfn[got] = pfn;
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5A17));
    pend_pr = 0; pend_rd = 0; free_probe = 0;
    for (int i = 0; i < N; i++) begin
      m_v[i] = 0; m_g[i] = 0; m_d[i] = 0; m_perm[i] = 0;
      m_asid[i] = 0; m_vpn[i] = 0; m_pfn[i] = 0;
    end
    rst_n = 1'b0;
    lk_en = 0; lk_write = 0; lk_vaddr = 0; cur_asid = 0;
    mg_wired = 0;
    set_wr(3'd0, 4'd0, 20'd0, 8'd0, 20'd0, 1'b0, 1'b0, 1'b0, 2'b00);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R11 reset state
    #1;
    chk("R11 probe index", 64'(pr_index), 64'd0);
    chk("R11 probe miss", 64'(pr_miss), 64'd0);
    chk("R11 read outputs", 64'({rd_valid, rd_global, rd_dirty, rd_perm, rd_vpn}), 64'd0);
    nxt(); set_lk(32'h1234_5678, 8'd5, 1'b0); eval();
    chk("R11 lookup misses", 64'(lk_miss_exc), 64'd1);

    // initialize all slots as invalid (R7)
    for (int i = 0; i < N; i++) begin
      nxt(); set_wr(3'd3, 4'(i), 20'(i), 8'd0, 20'(i * 3), 1'b0, 1'b0, 1'b0, 2'b00); eval();
    end

    // R7: write and same-cycle lookup sees old contents
    nxt(); set_wr(3'd3, 4'd0, 20'h12345, 8'd5, 20'hABCDE, 1'b1, 1'b0, 1'b1, 2'b01);
    set_lk(32'h1234_5678, 8'd5, 1'b0); eval();
    chk("R7 same-cycle write unseen", 64'(lk_hit), 64'd0);
    nxt(); set_lk(32'h1234_5678, 8'd5, 1'b0); eval();
    chk("R1 translated address", 64'(lk_paddr), 64'hABCD_E678);
    nxt(); set_lk(32'h1234_5FFF, 8'd6, 1'b0); eval();   // R2 other space misses
    // R2 global override and R4 modify exception
    nxt(); set_wr(3'd3, 4'd1, 20'h00777, 8'd9, 20'h0F00D, 1'b1, 1'b1, 1'b0, 2'b11); eval();
    nxt(); set_lk(32'h0077_7001, 8'd3, 1'b0); eval();
    nxt(); set_lk(32'h0077_7001, 8'd3, 1'b1); eval();
    chk("R4 store to clean page", 64'(lk_mod_exc), 64'd1);
    nxt(); set_lk(32'h1234_5000, 8'd5, 1'b1); eval();   // R4 dirty page store: no exception
    // R3 miss leaves contents, R6 read back
    nxt(); set_lk(32'hDEAD_B000, 8'd5, 1'b1); eval();
    nxt(); mg_op = 3'd2; mg_index = 4'd0; eval();
    nxt(); mg_op = 3'd2; mg_index = 4'd1; eval();
    // R5 probe hit and miss
    nxt(); set_wr(3'd1, 4'd0, 20'h12345, 8'd5, 20'd0, 1'b0, 1'b0, 1'b0, 2'b00); eval();
    nxt(); set_wr(3'd1, 4'd0, 20'h12345, 8'd7, 20'd0, 1'b0, 1'b0, 1'b0, 2'b00); eval();
    nxt(); eval();
    chk("R5 probe miss flag", 64'(pr_miss), 64'd1);
    // R10 duplicate match: lowest index wins
    nxt(); set_wr(3'd3, 4'd7, 20'h55555, 8'd2, 20'h77777, 1'b1, 1'b0, 1'b1, 2'b00); eval();
    nxt(); set_wr(3'd3, 4'd3, 20'h55555, 8'd2, 20'h33333, 1'b1, 1'b0, 1'b1, 2'b01); eval();
    nxt(); set_lk(32'h5555_5123, 8'd2, 1'b0);
    set_wr(3'd1, 4'd0, 20'h55555, 8'd2, 20'd0, 1'b0, 1'b0, 1'b0, 2'b00); eval();
    chk("R10 lowest slot frame", 64'(lk_paddr), 64'h3333_3123);
    nxt(); eval();
    // R8 random writes with four pinned slots
    mg_wired = 4'd4;
    for (int k = 0; k < 24; k++) rnd_write(20'h0C000 + 20'(k), 8'(k), 20'h40000 + 20'(k));
    for (int i = 0; i < 4; i++) begin
      nxt(); mg_op = 3'd2; mg_index = 4'(i); eval();   // R8 pinned slots intact
    end
    mg_wired = 4'd0;
    // R9 flush
    nxt(); mg_op = 3'd5; eval();
    nxt(); set_lk(32'h0077_7001, 8'd9, 1'b0); eval();
    chk("R9 no hit after flush", 64'(lk_hit), 64'd0);
    nxt(); mg_op = 3'd2; mg_index = 4'd1; eval();
    nxt(); eval();

    // constrained random phase
    for (int s = 0; s < 3000; s++) begin
      int r;
      nxt();
      r = int'($urandom_range(0, 99));
      if (r < 70)
        set_lk({20'hA0000 + 20'($urandom_range(0, 7)), 12'($urandom)},
               8'($urandom_range(0, 3)), 1'($urandom));
      r = int'($urandom_range(0, 99));
      if (r < 30)
        set_wr(3'd3, 4'($urandom), 20'hA0000 + 20'($urandom_range(0, 7)),
               8'($urandom_range(0, 3)), 20'($urandom), ($urandom_range(0, 9) < 8),
               ($urandom_range(0, 9) < 2), 1'($urandom), 2'($urandom));
      else if (r < 45)
        set_wr(3'd1, 4'd0, 20'hA0000 + 20'($urandom_range(0, 7)),
               8'($urandom_range(0, 3)), 20'd0, 1'b0, 1'b0, 1'b0, 2'b00);
      else if (r < 60) begin mg_op = 3'd2; mg_index = 4'($urandom); end
      else if (r == 60) mg_op = 3'd5;
      eval();
    end
    nxt(); eval();

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule